// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects sixteen interrupt sources of a multi-function peripheral and presents them to a processor as a single request line with a vectored acknowledge. Eight of the sources come from an 8-bit general-purpose port. Each port pin can be set as an input or an output, and each input pin has its own choice of rising or falling edge. The other eight sources are one-cycle event strobes from neighbouring functions such as timers and the serial channel. Those functions are outside this block.

The sources are held in two 8-bit banks: an upper bank for sources 15..8 and a lower bank for sources 7..0. Each bank has four registers: enable, pending, in-service and mask. Priority is fixed, and a higher source number wins. On acknowledge the block returns an 8-bit vector. Its upper nibble is programmable and its lower nibble is the number of the winning source. A mode bit selects how interrupts end:
- In software end-of-interrupt mode, an acknowledged source is marked in service and blocks equal and lower sources until the CPU clears the mark.
- In automatic mode, nothing is marked in service.

The CPU reaches all registers through a plain register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_req` is 0, `gp_oe` is 0 and `gp_out` is 0.
- R2: Register addresses are: 0 port, 1 edge select, 2 direction, 3 upper enable, 4 lower enable, 5 upper pending, 6 lower pending, 7 upper in-service, 8 lower in-service, 9 upper mask, 10 lower mask, 11 vector control. Addresses 12..15 read 0 and ignore writes. Vector control bits 2:0 always read 0.
- R3: An input pin (direction bit 0) produces an event when it rises if its edge bit is 1, and when it falls if its edge bit is 0. Routing of events to sources:
  - pins 3..0 go to sources 3..0;
  - pins 5..4 go to sources 7..6;
  - pins 7..6 go to sources 15..14;
  - `dev_evt` bits 1..0 go to sources 5..4;
  - `dev_evt` bits 7..2 go to sources 13..8.
  Source n is upper-bank bit n-8 for n>=8 and lower-bank bit n otherwise.
- R4: A pin with direction bit 1 is driven (`gp_oe`=1) from the port latch and produces no event. A port read returns the latch for output pins and `gp_pin_in` for input pins.
- R5: An event sets a pending bit only if the source is enabled. Writing an enable bit to 0 clears that pending bit.
- R6: Writing 0 to a pending bit clears it and writing 1 leaves it unchanged. A new event in the same cycle keeps the bit set.
- R7: A mask bit of 1 lets its pending source request. A mask bit of 0 blocks the request, and the pending bit stays readable.
- R8: `irq_req` is 1 only when the highest-numbered pending, unmasked source is numbered above every in-service source.
- R9: While `irq_req` is 1, `irq_vector` equals {vector control bits 7:4, winning source number}. An acknowledge clears the winner's pending bit at the next edge.
- R10: With vector control bit 3 set to 1, an acknowledge sets the winner's in-service bit. Writing 0 to an in-service bit clears it and writing 1 leaves it unchanged.
- R11: With vector control bit 3 set to 0, an acknowledge never sets an in-service bit.
- R12: An acknowledge while `irq_req` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| gp_pin_in | input | 8 | Port pin levels, synchronous to `clk` |
| gp_out | output | 8 | Port output latch |
| gp_oe | output | 8 | Port drive enables (direction register) |
| dev_evt | input | 8 | One-cycle event strobes from neighbouring functions |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_ack | input | 1 | Interrupt acknowledge, one cycle |
| irq_vector | output | 8 | Vector for the current winner |

## Verification
The hardest state to reach is nesting. A low source sits in service while a higher one arrives and has to pre-empt it, and lower arrivals must stay blocked until the CPU clears the in-service bit. A directed sequence builds this state on purpose in software end-of-interrupt mode: acknowledge pin 3, raise pin 1 and expect no request, then raise source 13 and expect vector 0x4D. After that, a long random phase mixes register writes, pin toggles, strobes and acknowledges. A bench model shadows every register, so each cycle's read value, request and vector are compared.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW    = 8;
  localparam int NBANK = 2;
  localparam int NSRC  = DW * NBANK;
  localparam int IW    = $clog2(NSRC);
  localparam int AW    = 4;

  localparam logic [AW-1:0] RA_PORT  = 4'd0;
  localparam logic [AW-1:0] RA_EDGE  = 4'd1;
  localparam logic [AW-1:0] RA_DIR   = 4'd2;
  localparam logic [AW-1:0] RA_EN_U  = 4'd3;
  localparam logic [AW-1:0] RA_EN_L  = 4'd4;
  localparam logic [AW-1:0] RA_PND_U = 4'd5;
  localparam logic [AW-1:0] RA_PND_L = 4'd6;
  localparam logic [AW-1:0] RA_ISV_U = 4'd7;
  localparam logic [AW-1:0] RA_ISV_L = 4'd8;
  localparam logic [AW-1:0] RA_MSK_U = 4'd9;
  localparam logic [AW-1:0] RA_MSK_L = 4'd10;
  localparam logic [AW-1:0] RA_VEC   = 4'd11;

  typedef struct packed {
    logic          found;
    logic [IW-1:0] idx;
  } pick_t;

  // highest set bit of a source vector
  function automatic pick_t top_bit(input logic [NSRC-1:0] v);
    pick_t r;
    r = '0;
    for (int i = 0; i < NSRC; i++)
      if (v[i]) begin
        r.found = 1'b1;
        r.idx   = IW'(i);
      end
    return r;
  endfunction

  // a winner requests only above every in-service source
  function automatic logic outranks(input pick_t w, input pick_t s);
    return w.found && (!s.found || (w.idx > s.idx));
  endfunction

  // place pin and device events onto source numbers
  function automatic logic [NSRC-1:0] route_events(input logic [DW-1:0] pe,
                                                   input logic [DW-1:0] de);
    return {pe[7:6], de[7:2], pe[5:4], de[1:0], pe[3:0]};
  endfunction

  function automatic logic [DW-1:0] make_vector(input logic [3:0] hi,
                                                input logic [IW-1:0] idx);
    return {hi, idx};
  endfunction
endpackage

// File: rtl/irqc_gpio.sv
module irqc_gpio
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lat,
  input  logic          wr_edge,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] lat_q,
  output logic [DW-1:0] edge_q,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] port_view,
  output logic [DW-1:0] pin_evt
);
  logic [DW-1:0] prev_q;
  logic [DW-1:0] rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      edge_q <= '0;
      dir_q  <= '0;
      prev_q <= '0;
    end else begin
      if (wr_lat)  lat_q  <= wdata;
      if (wr_edge) edge_q <= wdata;
      if (wr_dir)  dir_q  <= wdata;
      prev_q <= pin_in;
    end
  end

  assign rise      = pin_in & ~prev_q;
  assign fall      = ~pin_in & prev_q;
  assign pin_evt   = ~dir_q & ((edge_q & rise) | (~edge_q & fall));
  assign port_view = (lat_q & dir_q) | (pin_in & ~dir_q);
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_r,
  input  logic         wr_pend,
  input  logic         wr_isvc,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] ack_clr,
  input  logic [W-1:0] isvc_set,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] isvc_q,
  output logic [W-1:0] mask_q
);
  logic [W-1:0] en_nxt, pend_keep, isvc_keep;

  assign en_nxt    = wr_en_r ? wdata : en_q;
  assign pend_keep = wr_pend ? wdata : '1;
  assign isvc_keep = wr_isvc ? wdata : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      isvc_q <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_nxt;
      pend_q <= ((pend_q & pend_keep & ~ack_clr) | evt) & en_nxt;
      isvc_q <= (isvc_q & isvc_keep) | isvc_set;
      if (wr_mask) mask_q <= wdata;
    end
  end

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~en_q) == '0); // R5
  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_clr) |=> ((pend_q & $past(ack_clr) & ~$past(evt)) == '0)); // R9
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  input  logic [NSRC-1:0] isvc,
  output pick_t           win,
  output logic            irq
);
  pick_t svc;
  assign win = top_bit(pend & mask);
  assign svc = top_bit(isvc);
  assign irq = outranks(win, svc);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] gp_pin_in,
  output logic [DW-1:0] gp_out,
  output logic [DW-1:0] gp_oe,
  input  logic [DW-1:0] dev_evt,
  output logic          irq_req,
  input  logic          irq_ack,
  output logic [DW-1:0] irq_vector
);
  logic [DW-1:0]   vr_q, edge_q, port_view, pin_evt;
  logic [NSRC-1:0] src_evt, en, pend, isvc, mask, ack_hot, isvc_set;
  logic            sw_eoi, ack_take;
  pick_t           win;

  irqc_gpio u_gpio (
    .clk, .rst_n,
    .wr_lat   (bus_wr && bus_addr == RA_PORT),
    .wr_edge  (bus_wr && bus_addr == RA_EDGE),
    .wr_dir   (bus_wr && bus_addr == RA_DIR),
    .wdata    (bus_wdata),
    .pin_in   (gp_pin_in),
    .lat_q    (gp_out),
    .edge_q   (edge_q),
    .dir_q    (gp_oe),
    .port_view(port_view),
    .pin_evt  (pin_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              vr_q <= '0;
    else if (bus_wr && bus_addr == RA_VEC)   vr_q <= {bus_wdata[7:3], 3'b000};
  end

  assign sw_eoi   = vr_q[3];
  assign src_evt  = route_events(pin_evt, dev_evt);
  assign ack_take = irq_ack && irq_req;
  assign ack_hot  = ack_take ? (NSRC'(1) << win.idx) : '0;
  assign isvc_set = sw_eoi ? ack_hot : '0;

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    localparam logic [AW-1:0] A_EN  = (k == 1) ? RA_EN_U  : RA_EN_L;
    localparam logic [AW-1:0] A_PND = (k == 1) ? RA_PND_U : RA_PND_L;
    localparam logic [AW-1:0] A_ISV = (k == 1) ? RA_ISV_U : RA_ISV_L;
    localparam logic [AW-1:0] A_MSK = (k == 1) ? RA_MSK_U : RA_MSK_L;
    irqc_bank #(.W(DW)) u_bank (
      .clk, .rst_n,
      .wr_en_r (bus_wr && bus_addr == A_EN),
      .wr_pend (bus_wr && bus_addr == A_PND),
      .wr_isvc (bus_wr && bus_addr == A_ISV),
      .wr_mask (bus_wr && bus_addr == A_MSK),
      .wdata   (bus_wdata),
      .evt     (src_evt[k*DW +: DW]),
      .ack_clr (ack_hot[k*DW +: DW]),
      .isvc_set(isvc_set[k*DW +: DW]),
      .en_q    (en[k*DW +: DW]),
      .pend_q  (pend[k*DW +: DW]),
      .isvc_q  (isvc[k*DW +: DW]),
      .mask_q  (mask[k*DW +: DW])
    );
  end

  irqc_arbiter u_arb (.pend(pend), .mask(mask), .isvc(isvc), .win(win), .irq(irq_req));

  assign irq_vector = make_vector(vr_q[7:4], win.idx);

  always_comb begin
    case (bus_addr)
      RA_PORT:  bus_rdata = port_view;
      RA_EDGE:  bus_rdata = edge_q;
      RA_DIR:   bus_rdata = gp_oe;
      RA_EN_U:  bus_rdata = en[15:8];
      RA_EN_L:  bus_rdata = en[7:0];
      RA_PND_U: bus_rdata = pend[15:8];
      RA_PND_L: bus_rdata = pend[7:0];
      RA_ISV_U: bus_rdata = isvc[15:8];
      RA_ISV_L: bus_rdata = isvc[7:0];
      RA_MSK_U: bus_rdata = mask[15:8];
      RA_MSK_L: bus_rdata = mask[7:0];
      RA_VEC:   bus_rdata = vr_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_SW_ACK_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && sw_eoi) |=> ((isvc & $past(ack_hot)) == $past(ack_hot))); // R10
  AST_AUTO_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_eoi |=> ((isvc & ~$past(isvc)) == '0)); // R11
  AST_REQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend & mask) != '0)); // R7
  AST_IDLE_ACK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !bus_wr) |=> ((~pend & $past(pend)) == '0)); // R12
endmodule

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/100ps
module tb_irq_vector_ctrl;
  logic clk = 0, rst_n = 0, bus_wr = 0, irq_ack = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, gp_pin_in = 0, dev_evt = 0;
  logic [7:0] bus_rdata, gp_out, gp_oe, irq_vector;
  logic irq_req;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m_lat = 0, m_edge = 0, m_dir = 0, m_prev = 0, m_vr = 0;
  logic [15:0] m_en = 0, m_pend = 0, m_isvc = 0, m_mask = 0;
  logic [7:0]  last_rd, last_vec, pin_s = 0;
  logic        last_irq;

  irq_vector_ctrl dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int m_pick(input logic [15:0] v);
    int r = -1;
    for (int i = 0; i < 16; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit m_irq();
    int w = m_pick(m_pend & m_mask);
    return (w >= 0) && (w > m_pick(m_isvc));
  endfunction

  function automatic logic [7:0] m_read(input logic [3:0] a, input logic [7:0] pin);
    case (a)
      0: return (m_lat & m_dir) | (pin & ~m_dir);
      1: return m_edge;   2: return m_dir;
      3: return m_en[15:8];   4: return m_en[7:0];
      5: return m_pend[15:8]; 6: return m_pend[7:0];
      7: return m_isvc[15:8]; 8: return m_isvc[7:0];
      9: return m_mask[15:8]; 10: return m_mask[7:0];
      11: return m_vr;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      0: return "R4 port read";
      1, 2: return "R3 edge/dir read";
      3, 4: return "R5 enable read";
      5, 6: return "R6 pending read";
      7, 8: return "R10 in-service read";
      9, 10: return "R7 mask read";
      default: return "R2 map read";
    endcase
  endfunction

  task automatic cycle(input bit wr, input logic [3:0] a, input logic [7:0] wd,
                       input logic [7:0] pin, input logic [7:0] dev, input bit ack);
    logic [7:0]  ev8;
    logic [15:0] ev16, pclr, iclr, hot, en_n, pend_n, isvc_n;
    bit take;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; gp_pin_in = pin; dev_evt = dev; irq_ack = ack;
    #1;
    last_rd = bus_rdata; last_irq = irq_req; last_vec = irq_vector;
    chk(tag_of(a), {8'h0, bus_rdata}, {8'h0, m_read(a, pin)});
    chk("R4 drive", {gp_oe, gp_out}, {m_dir, m_lat});
    chk("R8 request", {15'h0, irq_req}, {15'h0, m_irq()});
    if (m_irq()) chk("R9 vector", {8'h0, irq_vector}, {8'h0, m_vr[7:4], 4'(m_pick(m_pend & m_mask))});
    for (int i = 0; i < 8; i++)
      ev8[i] = !m_dir[i] && (m_edge[i] ? (!m_prev[i] && pin[i]) : (m_prev[i] && !pin[i]));
    ev16 = {ev8[7:6], dev[7:2], ev8[5:4], dev[1:0], ev8[3:0]};
    take = ack && m_irq();
    hot  = take ? (16'h1 << m_pick(m_pend & m_mask)) : 16'h0;
    en_n = m_en; pclr = 16'hFFFF; iclr = 16'hFFFF;
    if (wr) case (a)
      3: en_n[15:8] = wd;  4: en_n[7:0] = wd;
      5: pclr[15:8] = wd;  6: pclr[7:0] = wd;
      7: iclr[15:8] = wd;  8: iclr[7:0] = wd;
      default: ;
    endcase
    pend_n = ((m_pend & pclr & ~hot) | ev16) & en_n;
    isvc_n = (m_isvc & iclr) | (m_vr[3] ? hot : 16'h0);
    @(posedge clk);
    m_en = en_n; m_pend = pend_n; m_isvc = isvc_n; m_prev = pin;
    if (wr) case (a)
      0: m_lat = wd; 1: m_edge = wd; 2: m_dir = wd;
      9: m_mask[15:8] = wd; 10: m_mask[7:0] = wd;
      11: m_vr = {wd[7:3], 3'b000};
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cycle(1, a, d, pin_s, 0, 0);
  endtask

  task automatic rd(input logic [3:0] a);
    cycle(0, a, 0, pin_s, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(4'd6);  chk("R1 reset pending", {8'h0, last_rd}, 16'h0);
    chk("R1 reset irq", {15'h0, last_irq}, 16'h0);
    rd(4'd11); chk("R1 reset vector reg", {8'h0, last_rd}, 16'h0);
    rd(4'd13); chk("R2 unused addr", {8'h0, last_rd}, 16'h0);
    // setup: pin7 output, rising edges, all enabled/unmasked, software EOI
    wr(2, 8'h80); wr(0, 8'h80); wr(1, 8'hFF);
    wr(3, 8'hFF); wr(4, 8'hFF); wr(9, 8'hFF); wr(10, 8'hFF); wr(11, 8'h48);
    pin_s = 8'h80; rd(0);
    rd(5); chk("R4 output pin no event", {8'h0, last_rd}, 16'h0);
    pin_s = 8'h88; rd(6);
    rd(6); chk("R3 rise on pin3", {8'h0, last_rd}, 16'h08);
    chk("R9 vector src3", {8'h0, last_vec}, 16'h43);
    cycle(0, 8, 0, pin_s, 0, 1);
    rd(8); chk("R10 ack marks service", {8'h0, last_rd}, 16'h08);
    rd(6); chk("R9 ack clears pending", {8'h0, last_rd}, 16'h0);
    pin_s = 8'h8A; rd(6);
    rd(6); chk("R8 lower blocked pend", {8'h0, last_rd}, 16'h02);
    chk("R8 lower blocked irq", {15'h0, last_irq}, 16'h0);
    cycle(0, 5, 0, pin_s, 8'h80, 0);
    rd(5); chk("R8 higher preempts", {15'h0, last_irq}, 16'h1);
    chk("R9 vector src13", {8'h0, last_vec}, 16'h4D);
    wr(9, 8'h00);
    rd(5); chk("R7 masked still pending", {8'h0, last_rd}, 16'h20);
    chk("R7 masked no irq", {15'h0, last_irq}, 16'h0);
    wr(6, 8'hFD);
    rd(6); chk("R6 write zero clears", {8'h0, last_rd}, 16'h0);
    wr(8, 8'hF7);
    rd(8); chk("R10 write zero clears service", {8'h0, last_rd}, 16'h0);
    wr(3, 8'h00);
    rd(5); chk("R5 disable clears pending", {8'h0, last_rd}, 16'h0);
    wr(10, 8'h00); pin_s = 8'h8E; rd(6);
    cycle(0, 6, 0, pin_s, 0, 1);
    rd(6); chk("R12 idle ack no effect", {8'h0, last_rd}, 16'h04);
    wr(11, 8'hFF);
    rd(11); chk("R2 vector low bits zero", {8'h0, last_rd}, 16'hF8);
    wr(11, 8'h40); wr(10, 8'hFF);
    rd(6); chk("R9 auto vector", {8'h0, last_vec}, 16'h42);
    cycle(0, 8, 0, pin_s, 0, 1);
    rd(8); chk("R11 auto no service", {8'h0, last_rd}, 16'h0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] a = 4'($urandom % 16);
      bit w = ($urandom % 3) == 0;
      logic [7:0] d = 8'($urandom);
      if (w && (a == 3 || a == 4 || a == 9 || a == 10) && ($urandom % 2)) d = 8'hFF;
      if (($urandom % 3) == 0) pin_s = pin_s ^ (8'h1 << ($urandom % 8));
      cycle(w, a, d, pin_s, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00, ($urandom % 4) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule